// File: doc/BRIEF.md
# Reorder Buffer with Gated Producer Search

This block keeps the results of an out-of-order core in program order. Each cycle the front end can place zero, one or two instructions into a circular buffer of tagged entries. Each entry records the 7-bit destination register of its instruction. The entry index is the tag handed to the execution units. The execution units return results on two write-back ports, in any order and after any latency. Each result marks its entry complete and may flag an exception or a mispredicted branch. The oldest entry retires once it is complete and clean, at most one per cycle.

A faulting entry has no effect until it becomes the oldest. At that point the whole buffer is emptied, and branch mispredictions take the same emptying path as exceptions. Rename logic can ask which in-flight entry will write a given register. The answer comes from an associative search over the destination fields of live entries, youngest match winning. A per-register in-flight count, kept outside the entries, gives a live bit for each register. When that bit is clear the search is skipped and "no producer" is returned.

Control is a two-state machine. In ST_RUN the buffer allocates, commits and flushes. The transition ST_RUN to ST_RECOVER is taken when the oldest entry is complete and faulting. The transition ST_RECOVER to ST_RUN is taken unconditionally after one cycle, during which allocation is refused.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o` is 1 for any request of 0 to 2, `commit_valid_o` and `flush_o` are 0, and a lookup of any register gives `lookup_hit_o`=0 and `lookup_searched_o`=0.
- R2: When `alloc_num_i` is 1 or 2 and `alloc_ready_o` is 1, the request is accepted at the clock edge. Slot 0 receives tag `alloc_tag0_o` and slot 1 receives `alloc_tag1_o`, which is `alloc_tag0_o`+1 modulo 16. Tags continue from the previous allocation and wrap from 15 to 0.
- R3: `alloc_ready_o` is 0 when fewer free entries remain than `alloc_num_i` requests, or when `alloc_num_i` is 3; nothing is allocated then.
- R4: A write-back sets its tag complete at the clock edge; both ports may write in the same cycle. `commit_valid_o` rises in the cycle after the oldest entry becomes complete. It reports that entry's tag and destination. Commits leave in strict allocation order, one per cycle.
- R5: An exception flag on a write-back has no visible effect while older entries remain. When its entry is oldest, `flush_o`=1 with `flush_exc_o`=1 and `commit_valid_o`=0 in that cycle.
- R6: A mispredict flag works through the same flush, giving `flush_o`=1 with `flush_exc_o`=0 once that entry is oldest and complete.
- R7: After a flush edge, every entry is gone and lookups miss. For one cycle `alloc_ready_o` is 0 (state ST_RECOVER). The next accepted allocation receives tag 0.
- R8: When the looked-up register has in-flight producers, `lookup_hit_o`=1 and `lookup_tag_o` is the youngest such entry's tag.
- R9: `lookup_searched_o` is 1 exactly when the looked-up register has an in-flight producer. When it is 0, `lookup_hit_o` is 0.
- R10: A register stays live while any producer remains. When the older of two producers commits, the lookup still hits the younger. After the last one commits, the register is no longer searched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_num_i | input | 2 | Number of entries requested this cycle (0..2) |
| alloc_dest0_i | input | 7 | Destination register of the older slot |
| alloc_dest1_i | input | 7 | Destination register of the younger slot |
| alloc_ready_o | output | 1 | Request of this size can be accepted |
| alloc_tag0_o | output | 4 | Tag for slot 0 |
| alloc_tag1_o | output | 4 | Tag for slot 1 |
| wb0_valid_i | input | 1 | Write-back port 0 strobe |
| wb0_tag_i | input | 4 | Tag completed on port 0 |
| wb0_exc_i | input | 1 | Port 0 result raised an exception |
| wb0_mispred_i | input | 1 | Port 0 result is a mispredicted branch |
| wb1_valid_i | input | 1 | Write-back port 1 strobe |
| wb1_tag_i | input | 4 | Tag completed on port 1 |
| wb1_exc_i | input | 1 | Port 1 result raised an exception |
| wb1_mispred_i | input | 1 | Port 1 result is a mispredicted branch |
| lookup_reg_i | input | 7 | Register whose producer is requested |
| lookup_searched_o | output | 1 | Associative search enabled by live bit |
| lookup_hit_o | output | 1 | An in-flight producer exists |
| lookup_tag_o | output | 4 | Tag of youngest producer |
| commit_valid_o | output | 1 | Oldest entry retires this cycle |
| commit_tag_o | output | 4 | Tag of retiring entry |
| commit_dest_o | output | 7 | Destination of retiring entry |
| flush_o | output | 1 | Buffer empties at this edge |
| flush_exc_o | output | 1 | Flush cause: 1 exception, 0 mispredict |

## Verification
A stale live count for a register can only be seen through the lookup outputs. It shows as a missed producer or as a search that stays enabled after the last producer leaves. Each scenario therefore ends with a lookup one cycle after the final commit. A head or tail pointer that is off by one shows within a single cycle, in the tag returned for the next allocation or retirement. A wrong full count shows at the 15-entry and 16-entry boundaries. A missed or late return from the recovery state shows in `alloc_ready_o` in the two cycles after `flush_o`.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int ROB_DEPTH = 16;   // power of two: pointers wrap naturally
    localparam int ARCH_REGS = 128;
    localparam int TAG_W     = $clog2(ROB_DEPTH);
    localparam int REG_W     = $clog2(ARCH_REGS);

    typedef struct packed {
        logic             live;
        logic             done;
        logic             exc;
        logic             mispred;
        logic [REG_W-1:0] dest;
    } rob_slot_t;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } rob_state_e;
endpackage

// File: rtl/rob_fsm.sv
module rob_fsm
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic head_fault_i,
    output logic run_o,
    output logic flush_go_o
);
    rob_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        run_o      = 1'b0;
        flush_go_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                run_o      = 1'b1;
                flush_go_o = head_fault_i;
                if (head_fault_i) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end
endmodule

// File: rtl/rob_livemap.sv
module rob_livemap #(
    parameter int NREG  = 128,
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    inc0_i,
    input  logic [$clog2(NREG)-1:0] inc0_reg_i,
    input  logic                    inc1_i,
    input  logic [$clog2(NREG)-1:0] inc1_reg_i,
    input  logic                    dec_i,
    input  logic [$clog2(NREG)-1:0] dec_reg_i,
    output logic [NREG-1:0]         live_o
);
    localparam int RW    = $clog2(NREG);
    localparam int CNT_W = $clog2(DEPTH + 1);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [CNT_W-1:0] cnt_q, cnt_d;
        logic             live_q;

        always_comb begin
            cnt_d = cnt_q
                  + CNT_W'(inc0_i && inc0_reg_i == RW'(r))
                  + CNT_W'(inc1_i && inc1_reg_i == RW'(r))
                  - CNT_W'(dec_i  && dec_reg_i  == RW'(r));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                live_q <= 1'b0;
            end else if (clear_i) begin
                cnt_q  <= '0;
                live_q <= 1'b0;
            end else begin
                cnt_q  <= cnt_d;
                live_q <= (cnt_d != '0);
            end
        end

        assign live_o[r] = live_q;
    end
endmodule

// File: rtl/rob_cam.sv
module rob_cam #(
    parameter int DEPTH = 16,
    parameter int REG_W = 7
) (
    input  logic [DEPTH-1:0][REG_W-1:0] dest_i,
    input  logic [DEPTH-1:0]            live_i,
    input  logic [$clog2(DEPTH)-1:0]    head_i,
    input  logic                        enable_i,
    input  logic [REG_W-1:0]            key_i,
    output logic                        hit_o,
    output logic [$clog2(DEPTH)-1:0]    tag_o
);
    localparam int TW = $clog2(DEPTH);
    logic [TW-1:0] idx;

    // Walk from oldest to youngest; the last match is the youngest producer.
    always_comb begin
        hit_o = 1'b0;
        tag_o = '0;
        idx   = '0;
        if (enable_i) begin
            for (int k = 0; k < DEPTH; k++) begin
                idx = head_i + TW'(k);
                if (live_i[idx] && dest_i[idx] == key_i) begin
                    hit_o = 1'b1;
                    tag_o = idx;
                end
            end
        end
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH,
    parameter int NREG  = ARCH_REGS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               alloc_num_i,
    input  logic [$clog2(NREG)-1:0]  alloc_dest0_i,
    input  logic [$clog2(NREG)-1:0]  alloc_dest1_i,
    output logic                     alloc_ready_o,
    output logic [$clog2(DEPTH)-1:0] alloc_tag0_o,
    output logic [$clog2(DEPTH)-1:0] alloc_tag1_o,
    input  logic                     wb0_valid_i,
    input  logic [$clog2(DEPTH)-1:0] wb0_tag_i,
    input  logic                     wb0_exc_i,
    input  logic                     wb0_mispred_i,
    input  logic                     wb1_valid_i,
    input  logic [$clog2(DEPTH)-1:0] wb1_tag_i,
    input  logic                     wb1_exc_i,
    input  logic                     wb1_mispred_i,
    input  logic [$clog2(NREG)-1:0]  lookup_reg_i,
    output logic                     lookup_searched_o,
    output logic                     lookup_hit_o,
    output logic [$clog2(DEPTH)-1:0] lookup_tag_o,
    output logic                     commit_valid_o,
    output logic [$clog2(DEPTH)-1:0] commit_tag_o,
    output logic [$clog2(NREG)-1:0]  commit_dest_o,
    output logic                     flush_o,
    output logic                     flush_exc_o
);
    localparam int TW    = $clog2(DEPTH);
    localparam int RW    = $clog2(NREG);
    localparam int CNT_W = TW + 1;

    typedef struct packed {
        logic          live;
        logic          done;
        logic          exc;
        logic          mispred;
        logic [RW-1:0] dest;
    } slot_t;

    slot_t [DEPTH-1:0]       slot_q;
    logic  [TW-1:0]          head_q, tail_q;
    logic  [CNT_W-1:0]       count_q;
    logic  [CNT_W-1:0]       free_w;
    logic                    run_w, flush_go_w, head_fault_w, commit_go_w;
    logic                    alloc_go_w, take1_w;
    logic  [NREG-1:0]        reg_live_w;
    logic  [DEPTH-1:0][RW-1:0] cam_dest_w;
    logic  [DEPTH-1:0]       cam_live_w;
    slot_t                   head_slot_w;

    assign head_slot_w  = slot_q[head_q];
    assign head_fault_w = head_slot_w.live && head_slot_w.done
                       && (head_slot_w.exc || head_slot_w.mispred);
    assign commit_go_w  = run_w && head_slot_w.live && head_slot_w.done
                       && !head_slot_w.exc && !head_slot_w.mispred;

    assign free_w        = CNT_W'(DEPTH) - count_q;
    assign alloc_ready_o = run_w && !head_fault_w && (alloc_num_i != 2'd3)
                        && (free_w >= CNT_W'(alloc_num_i));
    assign alloc_go_w    = alloc_ready_o && (alloc_num_i != 2'd0);
    assign take1_w       = alloc_go_w && (alloc_num_i == 2'd2);
    assign alloc_tag0_o  = tail_q;
    assign alloc_tag1_o  = tail_q + TW'(1);

    assign commit_valid_o = commit_go_w;
    assign commit_tag_o   = head_q;
    assign commit_dest_o  = head_slot_w.dest;
    assign flush_o        = flush_go_w;
    assign flush_exc_o    = flush_go_w && head_slot_w.exc;

    rob_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_fault_i(head_fault_w),
        .run_o       (run_w),
        .flush_go_o  (flush_go_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (flush_go_w) begin
            slot_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (wb0_valid_i && slot_q[wb0_tag_i].live) begin
                slot_q[wb0_tag_i].done    <= 1'b1;
                slot_q[wb0_tag_i].exc     <= wb0_exc_i;
                slot_q[wb0_tag_i].mispred <= wb0_mispred_i;
            end
            if (wb1_valid_i && slot_q[wb1_tag_i].live) begin
                slot_q[wb1_tag_i].done    <= 1'b1;
                slot_q[wb1_tag_i].exc     <= wb1_exc_i;
                slot_q[wb1_tag_i].mispred <= wb1_mispred_i;
            end
            if (commit_go_w) begin
                slot_q[head_q].live <= 1'b0;
                head_q              <= head_q + TW'(1);
            end
            if (alloc_go_w) begin
                slot_q[alloc_tag0_o] <= '{live: 1'b1, done: 1'b0, exc: 1'b0,
                                          mispred: 1'b0, dest: alloc_dest0_i};
                if (take1_w)
                    slot_q[alloc_tag1_o] <= '{live: 1'b1, done: 1'b0, exc: 1'b0,
                                              mispred: 1'b0, dest: alloc_dest1_i};
                tail_q <= tail_q + TW'(alloc_num_i);
            end
            count_q <= count_q + (alloc_go_w ? CNT_W'(alloc_num_i) : '0)
                               - CNT_W'(commit_go_w);
        end
    end

    rob_livemap #(.NREG(NREG), .DEPTH(DEPTH)) u_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (flush_go_w),
        .inc0_i    (alloc_go_w),
        .inc0_reg_i(alloc_dest0_i),
        .inc1_i    (take1_w),
        .inc1_reg_i(alloc_dest1_i),
        .dec_i     (commit_go_w),
        .dec_reg_i (head_slot_w.dest),
        .live_o    (reg_live_w)
    );

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cam_dest_w[i] = slot_q[i].dest;
            cam_live_w[i] = slot_q[i].live;
        end
    end

    assign lookup_searched_o = reg_live_w[lookup_reg_i];

    rob_cam #(.DEPTH(DEPTH), .REG_W(RW)) u_cam (
        .dest_i  (cam_dest_w),
        .live_i  (cam_live_w),
        .head_i  (head_q),
        .enable_i(lookup_searched_o),
        .key_i   (lookup_reg_i),
        .hit_o   (lookup_hit_o),
        .tag_o   (lookup_tag_o)
    );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               alloc_num_i,
    input logic                     alloc_ready_o,
    input logic [$clog2(DEPTH)-1:0] alloc_tag0_o,
    input logic [$clog2(DEPTH)-1:0] alloc_tag1_o,
    input logic                     lookup_searched_o,
    input logic                     lookup_hit_o,
    input logic                     commit_valid_o,
    input logic [$clog2(DEPTH)-1:0] commit_tag_o,
    input logic                     flush_o
);
    localparam int TW = $clog2(DEPTH);
    logic [TW-1:0] exp_head, exp_tail;
    int            occ;
    logic          take;

    assign take = alloc_ready_o && (alloc_num_i != 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_head <= '0;
            exp_tail <= '0;
            occ      <= 0;
        end else if (flush_o) begin
            exp_head <= '0;
            exp_tail <= '0;
            occ      <= 0;
        end else begin
            if (commit_valid_o) exp_head <= exp_head + TW'(1);
            if (take)           exp_tail <= exp_tail + TW'(alloc_num_i);
            occ <= occ + (take ? int'(alloc_num_i) : 0) - (commit_valid_o ? 1 : 0);
        end
    end

    p_tag_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && alloc_num_i == 2'd2) |-> alloc_tag1_o == alloc_tag0_o + TW'(1));
    p_tag_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> alloc_tag0_o == exp_tail);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (occ + int'(alloc_num_i)) <= DEPTH);
    p_commit_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid_o |-> commit_tag_o == exp_head);
    p_flush_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !commit_valid_o);
    p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (!alloc_ready_o && !commit_valid_o && !lookup_hit_o));
    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_searched_o |-> !lookup_hit_o);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .alloc_num_i      (alloc_num_i),
    .alloc_ready_o    (alloc_ready_o),
    .alloc_tag0_o     (alloc_tag0_o),
    .alloc_tag1_o     (alloc_tag1_o),
    .lookup_searched_o(lookup_searched_o),
    .lookup_hit_o     (lookup_hit_o),
    .commit_valid_o   (commit_valid_o),
    .commit_tag_o     (commit_tag_o),
    .flush_o          (flush_o)
);

// File: tb/rob_core_test.sv
module rob_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] alloc_num;
    logic [6:0] d0, d1, lk;
    logic       ardy, w0v, w0e, w0m, w1v, w1e, w1m;
    logic [3:0] t0, t1, w0t, w1t, ltag, ctag;
    logic       lsrch, lhit, cval, fl, flx;
    logic [6:0] cdest;
    int         errors = 0, checks = 0;
    logic       finished = 1'b0;

    always #2.5 clk = ~clk;

    rob_core uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_num_i(alloc_num), .alloc_dest0_i(d0), .alloc_dest1_i(d1),
        .alloc_ready_o(ardy), .alloc_tag0_o(t0), .alloc_tag1_o(t1),
        .wb0_valid_i(w0v), .wb0_tag_i(w0t), .wb0_exc_i(w0e), .wb0_mispred_i(w0m),
        .wb1_valid_i(w1v), .wb1_tag_i(w1t), .wb1_exc_i(w1e), .wb1_mispred_i(w1m),
        .lookup_reg_i(lk), .lookup_searched_o(lsrch), .lookup_hit_o(lhit),
        .lookup_tag_o(ltag), .commit_valid_o(cval), .commit_tag_o(ctag),
        .commit_dest_o(cdest), .flush_o(fl), .flush_exc_o(flx)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_num = 2'd0; d0 = '0; d1 = '0; lk = '0;
        w0v = 0; w0t = '0; w0e = 0; w0m = 0;
        w1v = 0; w1t = '0; w1e = 0; w1m = 0;
    endtask

    // Advance one clock edge and settle after the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        lk = 7'd5; alloc_num = 2'd2; settle();
        check("R1", "ready", ardy, 1);
        check("R1", "commit", cval, 0);
        check("R1", "flush", fl, 0);
        check("R1", "searched", lsrch, 0);
        check("R1", "hit", lhit, 0);
        alloc_num = 2'd0;
    endtask

    task automatic t_alloc_commit();
        alloc_num = 2'd2; d0 = 7'd10; d1 = 7'd11; settle();
        check("R2", "tag0", t0, 0);
        check("R2", "tag1", t1, 1);
        tick();
        alloc_num = 2'd1; d0 = 7'd12; settle();
        check("R2", "next tag0", t0, 2);
        tick();
        lk = 7'd10; settle();
        check("R8", "searched r10", lsrch, 1);
        check("R8", "hit r10", lhit, 1);
        check("R8", "tag r10", ltag, 0);
        w0v = 1; w0t = 4'd2; w1v = 1; w1t = 4'd1;
        tick();
        settle();
        check("R4", "no commit before head done", cval, 0);
        w0v = 1; w0t = 4'd0;
        tick();
        settle();
        check("R4", "commit0 valid", cval, 1);
        check("R4", "commit0 tag", ctag, 0);
        check("R4", "commit0 dest", cdest, 10);
        tick();
        settle();
        check("R4", "commit1 tag", cval ? ctag : 99, 1);
        check("R4", "commit1 dest", cdest, 11);
        tick();
        settle();
        check("R4", "commit2 tag", cval ? ctag : 99, 2);
        tick();
        lk = 7'd10; settle();
        check("R4", "drained", cval, 0);
        check("R9", "r10 not searched", lsrch, 0);
        check("R9", "r10 no hit", lhit, 0);
    endtask

    task automatic t_youngest();
        alloc_num = 2'd2; d0 = 7'd20; d1 = 7'd20; settle();
        check("R2", "tags continue", t0, 3);
        tick();
        lk = 7'd20; settle();
        check("R8", "youngest hit", lhit, 1);
        check("R8", "youngest tag", ltag, 4);
        w0v = 1; w0t = 4'd3;
        tick();
        settle();
        check("R4", "commit tag3", cval ? ctag : 99, 3);
        tick();
        lk = 7'd20; settle();
        check("R10", "still searched", lsrch, 1);
        check("R10", "still hit", lhit, 1);
        check("R10", "remaining tag", ltag, 4);
        w1v = 1; w1t = 4'd4;
        tick();
        settle();
        check("R4", "commit tag4", cval ? ctag : 99, 4);
        tick();
        lk = 7'd20; settle();
        check("R10", "released searched", lsrch, 0);
        check("R10", "released hit", lhit, 0);
    endtask

    task automatic t_full_exception();
        for (int k = 0; k < 7; k++) begin
            alloc_num = 2'd2; d0 = 7'(30 + 2 * k); d1 = 7'(31 + 2 * k);
            tick();
        end
        alloc_num = 2'd1; d0 = 7'd60; settle();
        check("R2", "wrap tag", t0, 3);
        tick();
        alloc_num = 2'd2; settle();
        check("R3", "refuse 2 with 1 free", ardy, 0);
        alloc_num = 2'd3; settle();
        check("R3", "refuse 3", ardy, 0);
        alloc_num = 2'd1; d0 = 7'd61; settle();
        check("R3", "accept last slot", ardy, 1);
        check("R2", "last tag", t0, 4);
        tick();
        alloc_num = 2'd1; lk = 7'd30; settle();
        check("R3", "refuse when full", ardy, 0);
        check("R8", "r30 tag", lhit ? ltag : 99, 5);
        alloc_num = 2'd0;
        w0v = 1; w0t = 4'd5; w1v = 1; w1t = 4'd6; w1e = 1;
        tick();
        settle();
        check("R5", "older commits first", cval ? ctag : 99, 5);
        check("R5", "no early flush", fl, 0);
        tick();
        settle();
        check("R5", "flush at head", fl, 1);
        check("R5", "cause exception", flx, 1);
        check("R5", "no commit on flush", cval, 0);
        tick();
        alloc_num = 2'd1; lk = 7'd31; settle();
        check("R7", "recover not ready", ardy, 0);
        check("R7", "lookup cleared", lhit, 0);
        check("R7", "flush over", fl, 0);
        tick();
        alloc_num = 2'd1; d0 = 7'd50; settle();
        check("R7", "ready again", ardy, 1);
        check("R7", "tag restarts", t0, 0);
        tick();
    endtask

    task automatic t_mispredict();
        alloc_num = 2'd1; d0 = 7'd51; settle();
        check("R2", "second tag", t0, 1);
        tick();
        w0v = 1; w0t = 4'd1; w0m = 1;
        tick();
        settle();
        check("R6", "younger mispredict waits", fl, 0);
        check("R4", "head not done", cval, 0);
        w0v = 1; w0t = 4'd0;
        tick();
        settle();
        check("R4", "commit tag0", cval ? ctag : 99, 0);
        check("R4", "commit dest", cdest, 50);
        tick();
        settle();
        check("R6", "mispredict flush", fl, 1);
        check("R6", "cause branch", flx, 0);
        tick();
        settle();
        check("R7", "recover cycle", ardy, 0);
        tick();
        alloc_num = 2'd2; lk = 7'd51; settle();
        check("R7", "ready after mispredict", ardy, 1);
        check("R7", "tag zero", t0, 0);
        check("R7", "r51 gone", lhit, 0);
        alloc_num = 2'd0;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alloc_commit();
        tick();
        t_youngest();
        tick();
        t_full_exception();
        t_mispredict();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule